// File: doc/BRIEF.md
# Transmit Inhibit and Receive Flush Pin Control

This block gives one asynchronous control pin of a token-ring style MAC two possible meanings, chosen by a 2-bit function field. In flush mode, a rising edge of the pin asks the receive path to drop the frame it is currently taking in. The request is a single-cycle pulse. In inhibit mode, the pin holding high stops transmission in an orderly way. A frame already on the wire is allowed to finish. The token is then handed back, and the transmit gate stays shut until the pin goes low again. In the two remaining field values the pin has no effect.

The pin passes through a synchronizer before any decoding. The function field is registered, and that register clears to the normal setting. The MAC's ring timers and protocol machines are not touched by this block. Only the transmit gate and the token-release request are driven from here.

Top module: `xmit_gate_ctl`

## Requirements
- R1: After reset, `rx_flush_o` = 0, `token_rel_o` = 0 and `tx_gate_o` = 1. The registered function field reads 00 (normal).
- R2: With function field 00, the pin has no effect at either level: no flush pulse, no release, and the gate stays at 1.
- R3: Function field 11 is reserved and behaves exactly like 00.
- R4: With field 01, a pin rise that is held over three rising clock edges gives `rx_flush_o` = 1 in the cycle after the third edge. The latency comes from two synchronizer flops plus one output flop. A change of the field to 01 while the synchronized pin is already high gives the pulse two edges after the change.
- R5: The flush output is high for exactly one cycle per qualified rise. A pin held high gives no further pulses. A new pulse needs the pin to fall and rise again.
- R6: With field 10, a pin that is high and synchronized, while no frame is being sent and no token is held, closes the gate on the third edge after the pin rise. No release is issued.
- R7: If a token is held and no frame is in flight when the inhibit level appears, `token_rel_o` is high for exactly one cycle, starting on the same edge on which the gate closes.
- R8: If `tx_busy_i` = 1 and `tx_eof_i` = 0 when the inhibit level appears, the gate closes but no release is issued until an edge on which `tx_eof_i` = 1. The release follows on that edge if `token_held_i` = 1.
- R9: The gate reopens on the third edge after the pin falls in inhibit mode, once any pending release has been issued.
- R10: In field 01 the pin never closes the gate. In field 10 the pin never produces a flush pulse.
- R11: Changing the field away from 10 while the gate is closed reopens the gate two edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_pin_i | input | 1 | Asynchronous control pin |
| pin_fn_i | input | 2 | Pin function: 00 normal, 01 flush, 10 inhibit, 11 reserved |
| tx_busy_i | input | 1 | A frame is currently being transmitted |
| tx_eof_i | input | 1 | Strobe marking the end of the transmitted frame |
| token_held_i | input | 1 | The station holds the token |
| rx_flush_o | output | 1 | One-cycle request to discard the frame being received |
| token_rel_o | output | 1 | One-cycle request to release the token |
| tx_gate_o | output | 1 | 1 allows a new transmission to start |

## Verification
The pin is driven high and low under each of the four field values. This shows that only field 01 yields flush pulses, only field 10 moves the gate, and that 00 and 11 cannot be told apart. The inhibit case is tried in three states: idle without a token, idle with a token, and in the middle of a frame. These separate the no-release, immediate-release and release-after-end-of-frame paths. The field is also switched while the gate is closed and while the pin is high. This exposes whether the reopening and flush edge detection follow the qualified level rather than the raw pin. Long random runs mix all of these against a cycle model kept in the bench.

// File: rtl/xgc_pkg.sv
package xgc_pkg;

  typedef enum logic [1:0] {
    PF_NORMAL  = 2'b00,
    PF_FLUSH   = 2'b01,
    PF_INHIBIT = 2'b10,
    PF_RSVD    = 2'b11
  } pin_fn_e;

  typedef enum logic [1:0] {
    GS_RUN     = 2'b00,
    GS_DRAIN   = 2'b01,
    GS_RELEASE = 2'b10,
    GS_BLOCK   = 2'b11
  } gate_st_e;

  // qualified pin level that requests a receive flush
  function automatic logic flush_level(input logic [1:0] fn, input logic pin);
    return pin && (fn == PF_FLUSH);
  endfunction

  // qualified pin level that requests transmit inhibit
  function automatic logic inhibit_level(input logic [1:0] fn, input logic pin);
    return pin && (fn == PF_INHIBIT);
  endfunction

  // state reached from RUN once the inhibit level is seen
  function automatic gate_st_e inhibit_entry(input logic busy, input logic eof,
                                             input logic token);
    if (busy && !eof) return GS_DRAIN;
    if (token)        return GS_RELEASE;
    return GS_BLOCK;
  endfunction

endpackage

// File: rtl/xgc_sync.sv
module xgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[LAST];

endmodule

// File: rtl/xgc_decode.sv
module xgc_decode
  import xgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pin_fn_i,
  input  logic       pin_s_i,
  output logic       rx_flush_o,
  output logic       inhibit_o
);
  logic [1:0] fn_q;
  logic       flush_lvl;
  logic       flush_lvl_q;
  logic       flush_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fn_q <= PF_NORMAL;
    else        fn_q <= pin_fn_i;
  end

  assign flush_lvl  = flush_level(fn_q, pin_s_i);
  assign inhibit_o  = inhibit_level(fn_q, pin_s_i);
  assign flush_rise = flush_lvl && !flush_lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_lvl_q <= 1'b0;
      rx_flush_o  <= 1'b0;
    end else begin
      flush_lvl_q <= flush_lvl;
      rx_flush_o  <= flush_rise;
    end
  end

  // flush is a pulse, never a level
  assert_flush_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_o |=> !rx_flush_o);

  // a pulse only comes from flush mode with the synced pin high
  assert_flush_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_o |-> ($past(fn_q) == PF_FLUSH) && $past(pin_s_i));

  // flush and inhibit never coexist
  assert_no_cross_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_o |-> !$past(inhibit_o));

  // normal and reserved field values block both paths
  assert_idle_modes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_q == PF_NORMAL || fn_q == PF_RSVD) |-> !inhibit_o && !flush_lvl);

endmodule

// File: rtl/xgc_gate.sv
module xgc_gate
  import xgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit_i,
  input  logic tx_busy_i,
  input  logic tx_eof_i,
  input  logic token_held_i,
  output logic token_rel_o,
  output logic tx_gate_o
);
  gate_st_e st_q, st_d;
  logic     drain_done;
  logic     reopen;

  assign drain_done = (st_q == GS_DRAIN) && tx_eof_i;
  assign reopen     = (st_q == GS_BLOCK) && !inhibit_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_RUN:     if (inhibit_i) st_d = inhibit_entry(tx_busy_i, tx_eof_i, token_held_i);
      GS_DRAIN:   if (drain_done) st_d = token_held_i ? GS_RELEASE : GS_BLOCK;
      GS_RELEASE: st_d = GS_BLOCK;
      GS_BLOCK:   if (reopen) st_d = GS_RUN;
      default:    st_d = GS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_RUN;
    else        st_q <= st_d;
  end

  assign token_rel_o = (st_q == GS_RELEASE);
  assign tx_gate_o   = (st_q == GS_RUN);

  assert_release_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    token_rel_o |=> !token_rel_o && !tx_gate_o);

  assert_release_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
    token_rel_o |-> $past(token_held_i));

  assert_gate_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_i && $past(inhibit_i)) |-> !tx_gate_o);

  assert_drain_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == GS_DRAIN) && !tx_eof_i) |=> !token_rel_o);

  assert_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reopen |=> tx_gate_o);

endmodule

// File: rtl/xmit_gate_ctl.sv
module xmit_gate_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_pin_i,
  input  logic [1:0] pin_fn_i,
  input  logic       tx_busy_i,
  input  logic       tx_eof_i,
  input  logic       token_held_i,
  output logic       rx_flush_o,
  output logic       token_rel_o,
  output logic       tx_gate_o
);
  logic pin_s;
  logic inhibit;

  xgc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ctl_pin_i),
    .q_o   (pin_s)
  );

  xgc_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_fn_i   (pin_fn_i),
    .pin_s_i    (pin_s),
    .rx_flush_o (rx_flush_o),
    .inhibit_o  (inhibit)
  );

  xgc_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit_i    (inhibit),
    .tx_busy_i    (tx_busy_i),
    .tx_eof_i     (tx_eof_i),
    .token_held_i (token_held_i),
    .token_rel_o  (token_rel_o),
    .tx_gate_o    (tx_gate_o)
  );

  // R1: nothing pending right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !rx_flush_o && !token_rel_o && tx_gate_o);

  // R10: a flush pulse never closes the gate on its own
  assert_flush_keeps_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush_o && $past(tx_gate_o) && !$past(inhibit)) |-> tx_gate_o);

endmodule

// File: tb/xmit_gate_ctl_bench.sv
module xmit_gate_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [1:0] fn = 2'b00;
  logic       busy = 1'b0;
  logic       eof = 1'b0;
  logic       tok = 1'b0;
  logic       flush_o, rel_o, gate_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmit_gate_ctl u_xmit_gate_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_pin_i(pin), .pin_fn_i(fn),
    .tx_busy_i(busy), .tx_eof_i(eof), .token_held_i(tok),
    .rx_flush_o(flush_o), .token_rel_o(rel_o), .tx_gate_o(gate_o)
  );

  // bench cycle model, written from the requirements
  logic       m_s1, m_s2, m_prev, m_flush;
  logic [1:0] m_fn;
  int         m_st; // 0 open, 1 finishing frame, 2 releasing, 3 shut

  function automatic bit qual(input logic [1:0] f, input logic p, input logic [1:0] want);
    return p && (f == want);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_fn <= 2'b00; m_prev <= 0; m_flush <= 0; m_st <= 0;
    end else begin
      m_s1 <= pin; m_s2 <= m_s1; m_fn <= fn;
      m_prev  <= qual(m_fn, m_s2, 2'b01);
      m_flush <= qual(m_fn, m_s2, 2'b01) && !m_prev;
      case (m_st)
        0: if (qual(m_fn, m_s2, 2'b10)) m_st <= (busy && !eof) ? 1 : (tok ? 2 : 3);
        1: if (eof) m_st <= tok ? 2 : 3;
        2: m_st <= 3;
        default: if (!qual(m_fn, m_s2, 2'b10)) m_st <= 0;
      endcase
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // drive, cross one edge, compare with the model at the falling edge
  task automatic step(input logic p, input logic [1:0] f, input logic b,
                      input logic e, input logic t);
    pin = p; fn = f; busy = b; eof = e; tok = t;
    @(posedge clk);
    @(negedge clk);
    chk("R4 flush", flush_o, m_flush);
    chk("R7 release", rel_o, (m_st == 2));
    chk("R6 gate", gate_o, (m_st == 0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0425));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", flush_o, 1'b0); chk("R1", rel_o, 1'b0); chk("R1", gate_o, 1'b1);

    // R2 normal field, pin toggling
    for (int i = 0; i < 8; i++) begin
      step(i[1], 2'b00, 0, 0, 1);
      chk("R2", flush_o, 1'b0); chk("R2", gate_o, 1'b1);
    end
    // R3 reserved field
    for (int i = 0; i < 8; i++) begin
      step(i[1], 2'b11, 0, 0, 1);
      chk("R3", flush_o, 1'b0); chk("R3", gate_o, 1'b1); chk("R3", rel_o, 1'b0);
    end

    // R4 / R5 flush latency and single pulse
    repeat (4) step(0, 2'b01, 0, 0, 0);
    step(1, 2'b01, 0, 0, 0); chk("R4", flush_o, 1'b0);
    step(1, 2'b01, 0, 0, 0); chk("R4", flush_o, 1'b0);
    step(1, 2'b01, 0, 0, 0); chk("R4", flush_o, 1'b1);
    step(1, 2'b01, 0, 0, 0); chk("R5", flush_o, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1, 2'b01, 0, 0, 0); chk("R5", flush_o, 1'b0); chk("R10", gate_o, 1'b1);
    end
    // R4 field switched to flush while pin already synced high
    repeat (4) step(1, 2'b00, 0, 0, 0);
    step(1, 2'b01, 0, 0, 0); chk("R4", flush_o, 1'b0);
    step(1, 2'b01, 0, 0, 0); chk("R4", flush_o, 1'b1);
    step(0, 2'b01, 0, 0, 0); chk("R5", flush_o, 1'b0);

    // R6 inhibit, idle, no token
    repeat (4) step(0, 2'b10, 0, 0, 0);
    step(1, 2'b10, 0, 0, 0); step(1, 2'b10, 0, 0, 0); chk("R6", gate_o, 1'b1);
    step(1, 2'b10, 0, 0, 0); chk("R6", gate_o, 1'b0); chk("R6", rel_o, 1'b0);
    chk("R10", flush_o, 1'b0);
    repeat (3) step(1, 2'b10, 0, 0, 0);
    // R9 reopen after pin falls
    step(0, 2'b10, 0, 0, 0); step(0, 2'b10, 0, 0, 0); chk("R9", gate_o, 1'b0);
    step(0, 2'b10, 0, 0, 0); chk("R9", gate_o, 1'b1);

    // R7 inhibit, idle, token held
    step(1, 2'b10, 0, 0, 1); step(1, 2'b10, 0, 0, 1);
    step(1, 2'b10, 0, 0, 1); chk("R7", rel_o, 1'b1); chk("R7", gate_o, 1'b0);
    step(1, 2'b10, 0, 0, 1); chk("R7", rel_o, 1'b0);
    // R11 leave inhibit field while shut
    step(1, 2'b00, 0, 0, 0); chk("R11", gate_o, 1'b0);
    step(1, 2'b00, 0, 0, 0); chk("R11", gate_o, 1'b1);

    // R8 inhibit during a frame
    repeat (3) step(0, 2'b10, 1, 0, 1);
    step(1, 2'b10, 1, 0, 1); step(1, 2'b10, 1, 0, 1);
    step(1, 2'b10, 1, 0, 1); chk("R8", gate_o, 1'b0); chk("R8", rel_o, 1'b0);
    step(1, 2'b10, 1, 0, 1); chk("R8", rel_o, 1'b0);
    step(1, 2'b10, 1, 1, 1); chk("R8", rel_o, 1'b1);
    step(1, 2'b10, 0, 0, 1); chk("R8", rel_o, 1'b0);
    repeat (4) step(0, 2'b10, 0, 0, 0);
    chk("R9", gate_o, 1'b1);

    // constrained random mix
    begin
      logic p = 0, b = 0, t = 0, e;
      logic [1:0] f = 2'b10;
      for (int i = 0; i < 6000; i++) begin
        if ($urandom_range(7) == 0) p = ~p;
        if ($urandom_range(40) == 0) f = 2'($urandom_range(3));
        if ($urandom_range(15) == 0) t = ~t;
        e = b && ($urandom_range(5) == 0);
        step(p, f, b, e, t);
        if (e) b = 0;
        else if (!b && gate_o && $urandom_range(3) == 0) b = 1;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule